// File: doc/BRIEF.md
# Ordered-Collision True Dual-Port RAM

This block is a synchronous memory with two fully symmetric ports, A and B, that run from one shared clock. In any cycle each port can read a word, write any subset of its bytes, or stay idle. A port acts only while its enable is high. A write also needs the write enable and at least one byte-enable bit.

When both ports touch the same word in the same cycle, the result is fixed: port A's operation is applied first and port B's second. A read therefore sees the effect of port A's write but not of port B's. When both ports write the same word, port B's bytes overwrite port A's bytes where the two overlap.

Each port has a one-register output path with no-change behaviour: a write never disturbs the port's data output. Each output register has its own synchronous active-low clear. The clear only ever sets the output to zero, and it leaves the stored contents untouched.

Top module: `tdp_ordered_ram`

## Requirements
- R1: A read (enable 1, write enable 0) samples the address at a rising clock edge, and the stored word appears on that port's data output right after that edge, one cycle of latency.
- R2: During a write, byte-enable bit i writes data bits [i*8 +: 8] (default 8-bit bytes) and leaves all other bytes of the word unchanged. An all-ones byte enable writes the whole word, and an all-zeros byte enable writes nothing.
- R3: On a cycle where a port writes (enable 1, write enable 1), that port's data output keeps its previous value.
- R4: With a port's enable at 0, that port neither reads nor writes, even with its write enable and byte enables at 1, and its data output holds.
- R5: When port A writes and port B reads the same address in one cycle, port B returns the word after port A's write: A's enabled bytes are new and the rest are old.
- R6: When port A reads and port B writes the same address in one cycle, port A returns the value stored before that cycle, and the word then holds port B's data.
- R7: When both ports write the same address in one cycle, bytes enabled on port B hold B's data afterwards. Bytes enabled only on port A hold A's data.
- R8: A port's output clear (active low, synchronous) sets that port's data output to zero on the next edge, even if a read is requested in the same cycle. It does not affect the other port or the stored contents.
- R9: Accesses of the two ports to different addresses in the same cycle are independent and both complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| a_rst_n | input | 1 | Port A output clear, synchronous, active low |
| a_en | input | 1 | Port A enable; gates read and write |
| a_we | input | 1 | Port A write enable |
| a_be | input | DATA_W/BYTE_W | Port A byte write enables |
| a_addr | input | $clog2(DEPTH) | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_rst_n | input | 1 | Port B output clear, synchronous, active low |
| b_en | input | 1 | Port B enable; gates read and write |
| b_we | input | 1 | Port B write enable |
| b_be | input | DATA_W/BYTE_W | Port B byte write enables |
| b_addr | input | $clog2(DEPTH) | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The hardest case to reach is a same-address collision in which the two ports enable different byte subsets. A wrong ordering only shows up in the bytes where the subsets differ, so the bench drives partial byte enables that overlap in part during collisions. It then reads the word back from the opposite port to see every byte. The same is done for the clear-versus-read race: a port is cleared while its read request is still asserted, and the next read confirms that the stored word survived.

// File: rtl/tdp_pkg.sv
// Package: shared types for the ordered-collision dual-port RAM.
// Assumes: nothing beyond the standard language.
package tdp_pkg;

    // Decoded per-port action for one cycle
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_READ  = 2'd1,
        ACT_WRITE = 2'd2
    } tdp_act_e;

endpackage

// File: rtl/tdp_port_ctl.sv
// Module: tdp_port_ctl
// Decodes one port's enable, write enable and byte enables into an action
// and per-byte write strobes. Assumes the enable gates everything else.
module tdp_port_ctl
    import tdp_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              en,
    input  logic              we,
    input  logic [NBYTES-1:0] be,
    output tdp_act_e          act,
    output logic [NBYTES-1:0] wstrb
);

    // Classify the cycle: idle, read or write
    always_comb begin
        if (!en)     act = ACT_IDLE;
        else if (we) act = ACT_WRITE;
        else         act = ACT_READ;
    end

    // One strobe per byte lane, qualified by enable and write enable
    for (genvar g = 0; g < NBYTES; g++) begin : g_strb
        assign wstrb[g] = en & we & be[g];
    end

endmodule

// File: rtl/tdp_storage.sv
// Module: tdp_storage
// Word array with byte-lane writes from two ports, port A applied before
// port B. Provides the read word each port sees in the current cycle:
// port A sees the stored word, port B sees it after port A's write.
// Assumes a single clock; contents are not reset.
module tdp_storage #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [NBYTES-1:0] a_wstrb,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [NBYTES-1:0] b_wstrb,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_word,
    output logic [DATA_W-1:0] b_word
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              same_addr;
    logic [DATA_W-1:0] b_stored;

    assign same_addr = (a_addr == b_addr);
    assign a_word    = mem[a_addr];
    assign b_stored  = mem[b_addr];

    // Port B view: take port A's byte where A writes the same word this cycle
    for (genvar g = 0; g < NBYTES; g++) begin : g_fwd
        assign b_word[g*BYTE_W +: BYTE_W] = (same_addr && a_wstrb[g])
            ? a_wdata[g*BYTE_W +: BYTE_W]
            : b_stored[g*BYTE_W +: BYTE_W];
    end

    // Byte-lane writes: A first, then B, so B's lanes win on overlap
    always_ff @(posedge clk) begin
        for (int i = 0; i < NBYTES; i++) begin
            if (a_wstrb[i]) mem[a_addr][i*BYTE_W +: BYTE_W] <= a_wdata[i*BYTE_W +: BYTE_W];
        end
        for (int i = 0; i < NBYTES; i++) begin
            if (b_wstrb[i]) mem[b_addr][i*BYTE_W +: BYTE_W] <= b_wdata[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/tdp_out_reg.sv
// Module: tdp_out_reg
// One port's output register: loads on a read, holds on a write or idle
// cycle, and clears to zero on a synchronous active-low clear that has
// priority. Assumes the action comes from tdp_port_ctl.
module tdp_out_reg
    import tdp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tdp_act_e          act,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] dout
);

    // Clear has priority; only a read loads the register
    always_ff @(posedge clk) begin
        if (!rst_n)              dout <= '0;
        else if (act == ACT_READ) dout <= word;
    end

    // Marks that a clear has been seen, so $past has a defined history
    logic chk_live;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live <= 1'b1;
    end

    // R1
    read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(act == ACT_READ) && $past(rst_n)) |-> (dout == $past(word)));

    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(act == ACT_WRITE) && $past(rst_n)) |-> $stable(dout));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(act == ACT_IDLE) && $past(rst_n)) |-> $stable(dout));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(!rst_n)) |-> (dout == '0));

endmodule

// File: rtl/tdp_ordered_ram.sv
// Module: tdp_ordered_ram
// True dual-port RAM on one clock with byte writes, no-change outputs and
// A-before-B collision ordering. Assumes DATA_W is a multiple of BYTE_W.
module tdp_ordered_ram
    import tdp_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              a_rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [NBYTES-1:0] a_be,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_rst_n,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [NBYTES-1:0] b_be,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    tdp_act_e          a_act, b_act;
    logic [NBYTES-1:0] a_wstrb, b_wstrb;
    logic [DATA_W-1:0] a_word, b_word;

    tdp_port_ctl #(.NBYTES(NBYTES)) u_ctl_a (
        .en(a_en), .we(a_we), .be(a_be), .act(a_act), .wstrb(a_wstrb)
    );

    tdp_port_ctl #(.NBYTES(NBYTES)) u_ctl_b (
        .en(b_en), .we(b_we), .be(b_be), .act(b_act), .wstrb(b_wstrb)
    );

    tdp_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mem (
        .clk(clk),
        .a_wstrb(a_wstrb), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_wstrb(b_wstrb), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_word(a_word), .b_word(b_word)
    );

    tdp_out_reg #(.DATA_W(DATA_W)) u_out_a (
        .clk(clk), .rst_n(a_rst_n), .act(a_act), .word(a_word), .dout(a_rdata)
    );

    tdp_out_reg #(.DATA_W(DATA_W)) u_out_b (
        .clk(clk), .rst_n(b_rst_n), .act(b_act), .word(b_word), .dout(b_rdata)
    );

endmodule

// File: tb/tb_tdp_ordered_ram.sv
module tb_tdp_ordered_ram;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int DW    = 32;
    localparam int BW    = 8;
    localparam int NB    = DW / BW;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          a_rst_n, a_en, a_we, b_rst_n, b_en, b_we;
    logic [NB-1:0] a_be, b_be;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] exp_a = '0;
    logic [DW-1:0] exp_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdp_ordered_ram #(.DEPTH(DEPTH), .DATA_W(DW), .BYTE_W(BW)) dut (
        .clk(clk),
        .a_rst_n(a_rst_n), .a_en(a_en), .a_we(a_we), .a_be(a_be),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_rst_n(b_rst_n), .b_en(b_en), .b_we(b_we), .b_be(b_be),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r = old;
        for (int i = 0; i < NB; i++)
            if (be[i]) r[i*BW +: BW] = nw[i*BW +: BW];
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive one cycle from a falling edge; model applies A then B; check after the edge
    task automatic step(input logic ar, input logic ae, input logic awe, input logic [NB-1:0] abe,
                        input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                        input logic br, input logic bee, input logic bwe, input logic [NB-1:0] bbe,
                        input logic [AW-1:0] ba, input logic [DW-1:0] bd, input string req);
        a_rst_n = ar; a_en = ae; a_we = awe; a_be = abe; a_addr = aa; a_wdata = ad;
        b_rst_n = br; b_en = bee; b_we = bwe; b_be = bbe; b_addr = ba; b_wdata = bd;
        if (!ar) exp_a = '0; else if (ae && !awe) exp_a = mdl[aa];
        if (ae && awe) mdl[aa] = merge(mdl[aa], ad, abe);
        if (!br) exp_b = '0; else if (bee && !bwe) exp_b = mdl[ba];
        if (bee && bwe) mdl[ba] = merge(mdl[ba], bd, bbe);
        @(posedge clk);
        @(negedge clk);
        check({req, " portA"}, a_rdata, exp_a);
        check({req, " portB"}, b_rdata, exp_b);
    endtask

    task automatic rd_a(input logic [AW-1:0] a, input string req);
        step(1, 1, 0, '0, a, '0, 1, 0, 0, '0, '0, '0, req);
    endtask

    task automatic rd_b(input logic [AW-1:0] a, input string req);
        step(1, 0, 0, '0, '0, '0, 1, 1, 0, '0, a, '0, req);
    endtask

    task automatic t_reset();
        step(0, 0, 0, '0, '0, '0, 0, 0, 0, '0, '0, '0, "R8 reset");
        step(0, 0, 0, '0, '0, '0, 0, 0, 0, '0, '0, '0, "R8 reset");
        check("R8 reset value A", a_rdata, 32'h0);
    endtask

    // R9: both ports write distinct words each cycle; outputs hold (R3)
    task automatic t_fill();
        for (int i = 0; i < DEPTH/2; i++)
            step(1, 1, 1, '1, AW'(i), 32'hA500_0000 ^ (i * 32'h0101_0101),
                 1, 1, 1, '1, AW'(i + DEPTH/2), 32'h5A00_0000 ^ (i * 32'h0011_0203), "R9 R3 fill");
    endtask

    task automatic t_read();
        step(1, 1, 0, '0, 6'd3, '0, 1, 1, 0, '0, 6'd40, '0, "R1 R9 dual read");
        check("R1 literal", a_rdata, 32'hA500_0000 ^ (3 * 32'h0101_0101));
        step(1, 1, 0, '0, 6'd63, '0, 1, 1, 0, '0, 6'd0, '0, "R1 R9 dual read");
        step(1, 1, 0, '0, 6'd7, '0, 1, 1, 0, '0, 6'd7, '0, "R1 same-address read");
    endtask

    task automatic t_bytes();
        step(1, 1, 1, 4'b0101, 6'd10, 32'h1122_3344, 1, 0, 0, '0, '0, '0, "R2 partial write");
        rd_b(6'd10, "R2 partial readback");
        step(1, 1, 1, 4'b0000, 6'd10, 32'hFFFF_FFFF, 1, 0, 0, '0, '0, '0, "R2 zero strobes");
        rd_b(6'd10, "R2 zero strobe readback");
        step(1, 0, 0, '0, '0, '0, 1, 1, 1, 4'b1000, 6'd11, 32'hCC00_0000, 1'b0 ? "" : "R2 top byte");
        rd_a(6'd11, "R2 top byte readback");
    endtask

    task automatic t_nochange();
        rd_a(6'd20, "R1 load before write");
        step(1, 1, 1, '1, 6'd20, 32'hDEAD_BEEF, 1, 0, 0, '0, '0, '0, "R3 A write holds output");
        rd_b(6'd21, "R1 load B");
        step(1, 0, 0, '0, '0, '0, 1, 1, 1, '1, 6'd21, 32'hFACE_0001, "R3 B write holds output");
        rd_a(6'd21, "R3 B write landed");
    endtask

    task automatic t_enable();
        rd_a(6'd30, "R1 load");
        step(1, 0, 1, '1, 6'd30, 32'h0BAD_0BAD, 1, 0, 1, '1, 6'd30, 32'h0BAD_0BAD, "R4 disabled write");
        rd_b(6'd30, "R4 memory unchanged");
        step(1, 0, 0, '0, 6'd5, '0, 1, 0, 0, '0, 6'd5, '0, "R4 disabled read holds");
    endtask

    task automatic t_collide();
        step(1, 1, 1, 4'b0011, 6'd12, 32'h7777_8888, 1, 1, 0, '0, 6'd12, '0, "R5 A write B read");
        rd_a(6'd12, "R5 stored after");
        step(1, 1, 0, '0, 6'd13, '0, 1, 1, 1, '1, 6'd13, 32'h1357_9BDF, "R6 A read B write");
        rd_a(6'd13, "R6 B data stored");
        step(1, 1, 1, '1, 6'd14, 32'hAAAA_AAAA, 1, 1, 1, 4'b1100, 6'd14, 32'hBBBB_BBBB, "R7 both write");
        rd_b(6'd14, "R7 merged readback");
        check("R7 literal", b_rdata, 32'hBBBB_AAAA);
        step(1, 1, 1, 4'b1001, 6'd15, 32'h1111_1111, 1, 1, 1, 4'b0011, 6'd15, 32'h2222_2222, "R7 partial overlap");
        rd_a(6'd15, "R7 partial overlap readback");
    endtask

    task automatic t_clear();
        rd_a(6'd2, "R1 load");
        rd_b(6'd3, "R1 load");
        step(0, 1, 0, '0, 6'd2, '0, 1, 1, 0, '0, 6'd4, '0, "R8 clear beats read");
        rd_a(6'd2, "R8 contents intact");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_read();
        t_bytes();
        t_nochange();
        t_enable();
        t_collide();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule